// File: doc/BRIEF.md
# Serial Flash Transaction Phase Sequencer

This block runs one serial NOR flash transaction at a time over a single-line SPI link. Before a transaction, the host sets up several things on plain configuration inputs: an 8-bit opcode, a 32-bit flash address, the address width, a dummy byte count, a 14-bit data byte count, a target device select and a 12-bit chip-select timing word. It then writes a 9-bit operation word whose start bit launches the transaction. The other bits of the word enable the phases one by one. The sequencer latches the whole setup at launch, lowers the selected chip-select and clocks out the enabled phases. It then raises chip-select and sets a sticky done flag.

Write data is fetched from a small internal byte buffer, and bytes clocked in on MISO during a read are stored back into it. The host loads and unloads the buffer through a simple byte port while the sequencer is idle. The SPI clock runs at half the system clock in mode 0. The setup, hold and deselect intervals around each frame are programmed in whole system-clock cycles.

Top module: `sfl_phase_seq`

## Requirements
- R1: After reset all chip-select outputs are high, SCLK and done are low and busy is low.
- R2: A one-cycle `op_wr` with `op_word[0]` set while idle starts one frame. Bit 7 enables a single command byte, which is `cfg_opcode`.
- R3: Enabled phases are sent in the fixed order command, address, dummy, data, and a disabled phase costs no SCLK edges. Each byte goes MSB first in SPI mode 0: MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R4: `op_word[6]` enables an address phase that sends `cfg_addr`, most significant byte first. It is 3 bytes long (bits 23:0) when `cfg_addr4` is 0 and 4 bytes long (bits 31:0) when it is 1.
- R5: `op_word[8]` enables a dummy phase of `cfg_dummy` whole bytes, each driven as 0x00 on MOSI. A dummy count of zero skips the phase.
- R6: `op_word[5]` sends `cfg_count` data bytes taken from buffer index i modulo the buffer depth. `op_word[2]` (data read) or `op_word[1]` (status read) sends 0x00 and stores received byte i at buffer index i. A count of zero skips the data phase.
- R7: In `cfg_timing`, setup is bits 7:4, hold is bits 11:8 and deselect is bits 3:0. The first SCLK rise comes exactly setup+4 cycles after chip-select falls, and chip-select rises exactly hold+2 cycles after the last SCLK fall. Done rises exactly deselect+1 cycles after chip-select rises.
- R8: During a frame, only the chip-select line numbered `cfg_cs` goes low.
- R9: Done sets at the end of a frame and stays set until a cycle with `done_clr` high, which clears it.
- R10: While busy, a further start request and host buffer writes are ignored: only one frame occurs, and the buffer content is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_opcode | input | 8 | Command byte |
| cfg_addr | input | 32 | Flash address |
| cfg_addr4 | input | 1 | 1 selects a 4-byte address, 0 a 3-byte address |
| cfg_dummy | input | 4 | Dummy byte count |
| cfg_count | input | CNT_W | Data byte count |
| cfg_cs | input | CS_W | Target device number |
| cfg_timing | input | 12 | Hold [11:8], setup [7:4], deselect [3:0] in cycles |
| op_wr | input | 1 | Operation word write strobe |
| op_word | input | 9 | Start and phase enable bits |
| done_clr | input | 1 | Clears the done flag |
| host_we | input | 1 | Buffer write strobe (idle only) |
| host_addr | input | BUF_AW | Buffer index for host access |
| host_wdata | input | 8 | Buffer write byte |
| host_rdata | output | 8 | Buffer read byte, one cycle after the address |
| sclk | output | 1 | SPI clock |
| cs_n | output | NUM_CS | Active-low chip-selects |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky completion flag |

## Verification
The hardest situations to reach are the ones that overlap a running frame: a second start request, and a host write aimed at the buffer the engine is reading. The stimulus fires both about ten cycles into a write frame, while the new opcode is still on the configuration inputs. It then checks that the captured stream still carries the original opcode, that exactly one chip-select frame occurred and that the buffer byte was not touched. Buffer wrap is reached with a write count larger than the buffer depth. Zero-length phases are covered by sweeping all sixteen phase-enable combinations together with varied counts and timings.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_DESEL} seq_state_t;

  // phase index; the numeric order is the transmit order
  localparam logic [1:0] SEG_CMD   = 2'd0;
  localparam logic [1:0] SEG_ADDR  = 2'd1;
  localparam logic [1:0] SEG_DUMMY = 2'd2;
  localparam logic [1:0] SEG_DATA  = 2'd3;

  // operation word bit positions
  localparam int OPB_START = 0;
  localparam int OPB_STAT  = 1;
  localparam int OPB_RD    = 2;
  localparam int OPB_WR    = 5;
  localparam int OPB_ADDR  = 6;
  localparam int OPB_CMD   = 7;
  localparam int OPB_DUMMY = 8;
endpackage

// File: rtl/sfl_cs_timer.sv
module sfl_cs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= value;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  logic [7:0] sreg;
  logic [2:0] bitcnt;
  logic       half;
  logic       active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0; bitcnt <= '0; half <= 1'b0; active <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0; rx_byte <= '0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        sreg   <= tx_byte;
        mosi   <= tx_byte[7];
        bitcnt <= '0;
        half   <= 1'b0;
        active <= 1'b1;
        sclk   <= 1'b0;
      end else if (active) begin
        if (!half) begin
          sclk    <= 1'b1;
          half    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          half <= 1'b0;
          if (bitcnt == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            sreg   <= {sreg[6:0], 1'b0};
            mosi   <= sreg[6];
          end
        end
      end
    end
  end

  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done); // R3
  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi)); // R3
endmodule

// File: rtl/sfl_buf.sv
module sfl_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/sfl_phase_seq.sv
module sfl_phase_seq
  import sfl_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int BUF_DEPTH = 16,
  parameter int CNT_W     = 14,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cfg_opcode,
  input  logic [31:0]       cfg_addr,
  input  logic              cfg_addr4,
  input  logic [3:0]        cfg_dummy,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic [11:0]       cfg_timing,
  input  logic              op_wr,
  input  logic [8:0]        op_word,
  input  logic              done_clr,
  input  logic              host_we,
  input  logic [BUF_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              done
);
  seq_state_t       state;
  logic [1:0]       ld, seg, first_seg, nxt_seg;
  logic [CNT_W-1:0] bcnt, cur_len;
  logic [CNT_W-1:0] seg_len [4];
  logic [3:0]       seg_en;
  logic             any_seg, has_next;
  logic             l_cmd, l_adr, l_dum, l_wr, l_rd, l_st, l_addr4;
  logic [7:0]       l_opcode;
  logic [31:0]      l_addr;
  logic [3:0]       l_dummy, l_hold, l_desel, tmr_val;
  logic [CNT_W-1:0] l_count;
  logic             start_ok, setup_exp, hold_exp, desel_exp, last_byte, to_hold;
  logic             tmr_load, tmr_zero, sh_load, byte_done, eng_we;
  logic [7:0]       tx_byte, rx_byte, eng_rdata;
  logic [1:0]       ab;
  logic [NUM_CS-1:0] cs_q;
  logic             done_q;
  logic             unused_bits;

  assign unused_bits = ^op_word[4:3];

  // phase lengths from the latched setup
  always_comb begin
    seg_len[SEG_CMD]   = CNT_W'(l_cmd);
    seg_len[SEG_ADDR]  = l_adr ? (l_addr4 ? CNT_W'(4) : CNT_W'(3)) : '0;
    seg_len[SEG_DUMMY] = l_dum ? CNT_W'(l_dummy) : '0;
    seg_len[SEG_DATA]  = (l_wr | l_rd | l_st) ? l_count : '0;
    first_seg = SEG_CMD;
    nxt_seg   = SEG_CMD;
    has_next  = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      seg_en[i] = (seg_len[i] != '0);
      if (seg_en[i]) first_seg = 2'(i);
      if (seg_en[i] && (2'(i) > seg)) begin
        nxt_seg  = 2'(i);
        has_next = 1'b1;
      end
    end
    any_seg = |seg_en;
    cur_len = seg_len[seg];
  end

  always_comb begin
    start_ok  = (state == ST_IDLE) && op_wr && op_word[OPB_START];
    setup_exp = (state == ST_SETUP) && tmr_zero;
    hold_exp  = (state == ST_HOLD) && tmr_zero;
    desel_exp = (state == ST_DESEL) && tmr_zero;
    last_byte = (state == ST_SHIFT) && (ld == 2'd2) && byte_done && ((bcnt + 1'b1) == cur_len);
    to_hold   = (setup_exp && !any_seg) || (last_byte && !has_next);
    tmr_load  = start_ok || to_hold || hold_exp;
    tmr_val   = start_ok ? cfg_timing[7:4] : (hold_exp ? l_desel : l_hold);
    sh_load   = (state == ST_SHIFT) && (ld == 2'd1);
    eng_we    = (state == ST_SHIFT) && (ld == 2'd2) && byte_done &&
                (seg == SEG_DATA) && (l_rd || l_st);
    ab        = (l_addr4 ? 2'd3 : 2'd2) - bcnt[1:0];
    case (seg)
      SEG_CMD:  tx_byte = l_opcode;
      SEG_ADDR: tx_byte = l_addr[{ab, 3'b000} +: 8];
      SEG_DATA: tx_byte = l_wr ? eng_rdata : 8'h00;
      default:  tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; ld <= '0; seg <= '0; bcnt <= '0;
      {l_cmd, l_adr, l_dum, l_wr, l_rd, l_st, l_addr4} <= '0;
      l_opcode <= '0; l_addr <= '0; l_dummy <= '0; l_count <= '0;
      l_hold <= '0; l_desel <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_ok) begin
          l_cmd <= op_word[OPB_CMD];  l_adr <= op_word[OPB_ADDR];
          l_dum <= op_word[OPB_DUMMY]; l_wr <= op_word[OPB_WR];
          l_rd  <= op_word[OPB_RD];   l_st <= op_word[OPB_STAT];
          l_opcode <= cfg_opcode; l_addr <= cfg_addr; l_addr4 <= cfg_addr4;
          l_dummy <= cfg_dummy; l_count <= cfg_count;
          l_hold <= cfg_timing[11:8]; l_desel <= cfg_timing[3:0];
          state <= ST_SETUP;
        end
        ST_SETUP: if (setup_exp) begin
          if (any_seg) begin
            state <= ST_SHIFT; seg <= first_seg; bcnt <= '0; ld <= 2'd0;
          end else state <= ST_HOLD;
        end
        ST_SHIFT: begin
          if (ld != 2'd2) ld <= ld + 1'b1;
          else if (byte_done) begin
            ld <= 2'd0;
            if ((bcnt + 1'b1) == cur_len) begin
              bcnt <= '0;
              if (has_next) seg <= nxt_seg;
              else state <= ST_HOLD;
            end else bcnt <= bcnt + 1'b1;
          end
        end
        ST_HOLD:  if (hold_exp)  state <= ST_DESEL;
        ST_DESEL: if (desel_exp) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)           cs_q[g] <= 1'b1;
      else if (start_ok) cs_q[g] <= (cfg_cs != CS_W'(g));
      else if (hold_exp) cs_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            done_q <= 1'b0;
    else if (desel_exp) done_q <= 1'b1;
    else if (done_clr)  done_q <= 1'b0;
  end

  sfl_cs_timer #(.W(4)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .value(tmr_val), .expired(tmr_zero));

  sfl_shifter u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .tx_byte(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte), .byte_done(byte_done));

  sfl_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk),
    .we((state != ST_IDLE) ? eng_we : host_we),
    .waddr((state != ST_IDLE) ? bcnt[BUF_AW-1:0] : host_addr),
    .wdata((state != ST_IDLE) ? rx_byte : host_wdata),
    .ra_addr(host_addr), .ra_data(host_rdata),
    .rb_addr(bcnt[BUF_AW-1:0]), .rb_data(eng_rdata));

  assign cs_n = cs_q;
  assign busy = (state != ST_IDLE);
  assign done = done_q;

  AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_q) <= 1); // R8
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (&cs_q && !sclk)); // R1
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !(&cs_q)); // R7
  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(state) == ST_DESEL)); // R9
endmodule

// File: tb/test_sfl_phase_seq.sv
`timescale 1ns/1ps
module test_sfl_phase_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  cfg_opcode;
  logic [31:0] cfg_addr;
  logic        cfg_addr4;
  logic [3:0]  cfg_dummy;
  logic [13:0] cfg_count;
  logic [0:0]  cfg_cs;
  logic [11:0] cfg_timing;
  logic        op_wr;
  logic [8:0]  op_word;
  logic        done_clr;
  logic        host_we;
  logic [3:0]  host_addr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        sclk, mosi, miso, busy, done;
  logic [1:0]  cs_n;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat_byte(input int k);
    return 8'((k * 29 + 75) & 255);
  endfunction
  function automatic logic [7:0] wr_pat(input int i);
    return 8'((i * 13 + 161) & 255);
  endfunction

  // SPI slave model
  int rise_cnt = 0;
  int nbits = 0;
  int frames = 0;
  bit first_rise = 1'b0;
  longint t_csfall = 0, t_rise = 0, t_fall = 0, t_csrise = 0, t_done = 0;
  logic [7:0] cap [64];
  logic [1:0] cs_seen;
  wire frame = ~&cs_n;

  function automatic logic miso_bit(input int n);
    logic [7:0] b;
    b = pat_byte(n >> 3);
    return b[7 - (n & 7)];
  endfunction
  assign miso = miso_bit(rise_cnt);

  always @(posedge frame) begin
    t_csfall = $time; rise_cnt = 0; nbits = 0; first_rise = 1'b1;
    frames++; cs_seen = cs_n;
  end
  always @(negedge frame) t_csrise = $time;
  always @(posedge done)  t_done = $time;
  always @(negedge sclk)  t_fall = $time;
  always @(posedge sclk) begin
    if (first_rise) begin t_rise = $time; first_rise = 1'b0; end
    if (nbits < 512) cap[nbits >> 3][7 - (nbits & 7)] = mosi;
    nbits++;
    rise_cnt++;
  end

  sfl_phase_seq i_sfl_phase_seq (
    .clk(clk), .rst(rst), .cfg_opcode(cfg_opcode), .cfg_addr(cfg_addr),
    .cfg_addr4(cfg_addr4), .cfg_dummy(cfg_dummy), .cfg_count(cfg_count),
    .cfg_cs(cfg_cs), .cfg_timing(cfg_timing), .op_wr(op_wr), .op_word(op_word),
    .done_clr(done_clr), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_buf(input int idx, input logic [7:0] v);
    @(negedge clk); host_we = 1'b1; host_addr = 4'(idx); host_wdata = v;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd_buf(input int idx, output logic [7:0] v);
    @(negedge clk); host_addr = 4'(idx);
    @(negedge clk); v = host_rdata;
  endtask

  task automatic run(input logic [8:0] op, input int count, input int dummy,
                     input bit a4, input bit cs, input logic [11:0] tim,
                     input logic [7:0] opc, input logic [31:0] adr, input bit poke);
    logic [7:0] exp [64];
    string tag [64];
    int n = 0;
    int off = 0;
    int w = 0;
    int al;
    logic [7:0] v;
    if (op[5]) for (int i = 0; i < 16; i++) wr_buf(i, wr_pat(i));
    frames = 0;
    @(negedge clk);
    cfg_opcode = opc; cfg_addr = adr; cfg_addr4 = a4; cfg_dummy = 4'(dummy);
    cfg_count = 14'(count); cfg_cs = cs; cfg_timing = tim; op_word = op; op_wr = 1'b1;
    @(negedge clk); op_wr = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      cfg_opcode = ~opc; op_wr = 1'b1;
      host_we = 1'b1; host_addr = 4'd5; host_wdata = 8'hEE;
      @(negedge clk); op_wr = 1'b0; host_we = 1'b0;
    end
    while (!done && w < 4000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R9 done set at frame end", done, 1);
    // expected MOSI stream
    if (op[7]) begin exp[n] = opc; tag[n] = "R2 command byte"; n++; end
    if (op[6]) begin
      al = a4 ? 4 : 3;
      for (int b = 0; b < al; b++) begin
        exp[n] = 8'(adr >> (8 * (al - 1 - b))); tag[n] = "R4 address byte"; n++;
      end
    end
    if (op[8]) for (int d = 0; d < dummy; d++) begin exp[n] = 8'h00; tag[n] = "R5 dummy byte"; n++; end
    off = n;
    if ((op[5] | op[2] | op[1]) && count > 0)
      for (int i = 0; i < count; i++) begin
        exp[n] = op[5] ? wr_pat(i % 16) : 8'h00; tag[n] = "R6 data byte"; n++;
      end
    chk(nbits == n * 8, "R3 SCLK rising edges in frame", nbits, n * 8);
    for (int k = 0; k < n && k < 64; k++) chk(cap[k] === exp[k], tag[k], cap[k], exp[k]);
    chk(frames == 1, poke ? "R10 single frame despite busy start" : "R2 single frame", frames, 1);
    chk(cs_seen == ~(2'b01 << cs), "R8 selected line low", cs_seen, ~(2'b01 << cs));
    if (n > 0) begin
      chk((t_rise - t_csfall) / 4 == tim[7:4] + 4, "R7 setup interval", (t_rise - t_csfall) / 4, tim[7:4] + 4);
      chk((t_csrise - t_fall) / 4 == tim[11:8] + 2, "R7 hold interval", (t_csrise - t_fall) / 4, tim[11:8] + 2);
    end
    chk((t_done - t_csrise) / 4 == tim[3:0] + 1, "R7 deselect interval", (t_done - t_csrise) / 4, tim[3:0] + 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R9 done stays set", done, 1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk(done == 1'b0, "R9 done cleared", done, 0);
    if ((op[2] | op[1]) && count > 0)
      for (int j = 0; j < count && j < 16; j++) begin
        rd_buf(j, v);
        chk(v == pat_byte(off + j), "R6 received byte stored", v, pat_byte(off + j));
      end
    if (poke) begin
      rd_buf(5, v);
      chk(v == wr_pat(5), "R10 buffer write while busy ignored", v, wr_pat(5));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [8:0] op;
    int data_on;
    rst = 1'b1; op_wr = 1'b0; op_word = '0; done_clr = 1'b0; host_we = 1'b0;
    host_addr = '0; host_wdata = '0; cfg_opcode = '0; cfg_addr = '0; cfg_addr4 = 1'b0;
    cfg_dummy = '0; cfg_count = '0; cfg_cs = '0; cfg_timing = '0;
    repeat (4) @(negedge clk);
    chk(cs_n == 2'b11, "R1 chip-selects high", cs_n, 3);
    chk(sclk == 1'b0, "R1 SCLK low", sclk, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(busy == 1'b0, "R1 idle", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    // sweep all phase-enable combinations, writing and reading
    for (int mode = 0; mode < 2; mode++)
      for (int c = 0; c < 16; c++) begin
        data_on = (c >> 3) & 1;
        op = 9'h001;
        if (c & 1) op[7] = 1'b1;
        if (c & 2) op[6] = 1'b1;
        if (c & 4) op[8] = 1'b1;
        if (data_on != 0) begin
          if (mode == 0) op[5] = 1'b1; else op[2] = 1'b1;
        end
        run(op, 1 + (c + mode) % 6, 1 + c % 3, ((c >> 1) & 1) ^ mode, (c & 1) ^ mode,
            {4'(c % 5), 4'((c * 3 + mode) % 7), 4'((c + 2 * mode) % 6)},
            8'(3 + c * 17), 32'h1234_5678 ^ (32'(c) * 32'h0101_0101), 1'b0);
      end
    // status read
    run(9'h083, 2, 0, 1'b0, 1'b1, 12'h213, 8'h05, 32'h0, 1'b0);
    // zero count with write enabled: data skipped
    run(9'h1E1, 0, 2, 1'b1, 1'b0, 12'h121, 8'h02, 32'hA1B2_C3D4, 1'b0);
    // write count beyond buffer depth wraps
    run(9'h0E1, 20, 0, 1'b0, 1'b1, 12'h000, 8'h02, 32'h00_0F_00_10, 1'b0);
    // longest timing fields
    run(9'h1C5, 3, 1, 1'b1, 1'b0, 12'hFFF, 8'h0B, 32'hDEAD_BEEF, 1'b0);
    // start request and buffer write while busy
    run(9'h0A1, 8, 0, 1'b0, 1'b0, 12'h111, 8'h32, 32'h0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule